// File: doc/BRIEF.md
# DMA Request Line Allocator

This block owns the table that binds a small pool of external DMA request lines to USB endpoints. A client asks for a line by giving an endpoint number and a direction. The block looks for a free line, records the endpoint and direction in that line's field of a mapping register, and returns a response one cycle later. The response carries a grant, a busy failure or a refusal, together with the line index and the request-output number that the line drives. A release names a line and returns it to the pool. Release and allocation also maintain a per-endpoint DMA interrupt mask, and a release produces a one-cycle clear pulse on the matching interrupt bit.

A static mode input selects the shared arrangement. In that arrangement only line 0 is used, and the whole mapping register must be empty before it can be granted. A shared release is accepted only when the endpoint recorded in line 0 matches the endpoint that is releasing. When an allocate and a release arrive in the same cycle, the release is applied first, so the allocate can take the line that has just been freed.

Top module: `dla_line_alloc`

## Requirements
- R1: After reset the mapping register reads 0, the interrupt mask reads 0x7FFFFFFF, the clear output reads 0, and no response or error is presented.
- R2: The mapping register holds one 5-bit field per line. Line i uses bits [5i+4:5i]. Bits [3:0] of a field hold the endpoint number and bit 4 is 1 for transmit and 0 for receive.
- R3: Outside shared mode, an allocate is granted the lowest line index from 0 to 4 whose endpoint subfield is zero, and the field is written with the requested endpoint and direction. Line 5 is never granted. The response comes one cycle after the request with status code 1 (grant) and the line index.
- R4: Outside shared mode, if lines 0 to 4 all hold a nonzero endpoint, the response has status code 2 (busy) and the map and mask are unchanged.
- R5: An allocate for endpoint 0 is answered with status code 3 (refused) in either mode and changes neither map nor mask.
- R6: A grant reports the request-output number of its line: lines 0, 1, 2, 3, 4 and 5 give 2, 3, 14, 15, 16 and 64. Any non-grant response reports 0.
- R7: Outside shared mode, releasing line k (0 to 4) whose endpoint subfield is nonzero clears all 5 bits of field k. Releasing a line index of 5 or more, or a line whose endpoint subfield is zero, raises the error output for one cycle and changes nothing else.
- R8: In shared mode, an allocate is granted line 0 only when the whole mapping register is zero. The register then becomes the endpoint number with bit 4 set for transmit. Otherwise the response is busy.
- R9: In shared mode, a release is honoured only when bits [3:0] of the register are nonzero and equal to the releasing endpoint, and the register is then cleared. A mismatch raises the error output for one cycle and leaves the register unchanged.
- R10: The mask bit for endpoint n is bit n for transmit and bit n+15 for receive. A grant clears the requester's bit. An honoured release sets the bit given by the endpoint and direction stored in the released field.
- R11: An honoured release drives the same mask bit position high on the clear output for exactly one cycle. Otherwise the clear output is zero.
- R12: For an allocate and a release in the same cycle, the release is applied to the map before the free-line search and the shared-mode emptiness check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shared_mode_i | input | 1 | 1 selects the single-line shared arrangement |
| alloc_req_i | input | 1 | Allocate request strobe |
| alloc_ep_i | input | 4 | Endpoint number to allocate for |
| alloc_tx_i | input | 1 | 1 for transmit, 0 for receive |
| rel_req_i | input | 1 | Release request strobe |
| rel_line_i | input | 3 | Line to release (ignored in shared mode) |
| rel_ep_i | input | 4 | Releasing endpoint (checked in shared mode) |
| rsp_valid_o | output | 1 | Response strobe, one cycle after an allocate |
| rsp_status_o | output | 2 | 1 grant, 2 busy, 3 refused |
| rsp_line_o | output | 3 | Granted line index |
| rsp_reqnum_o | output | 7 | Request-output number of the granted line |
| map_o | output | 30 | Mapping register |
| irq_mask_o | output | 31 | DMA interrupt mask |
| irq_clr_o | output | 31 | One-cycle interrupt clear pulse |
| rel_err_o | output | 1 | One-cycle pulse for a rejected release |

## Verification
Every result is registered. A request presented before clock edge k shows up in the response, the map, the mask, the clear pulse and the error flag right after edge k, and none of them lags behind the others. The bench changes inputs 1 ns after an edge, waits for the next edge and samples 1 ns later. At that point it compares every output against a model state advanced by one request, so a result that appears a cycle early or late is reported as a mismatch.

// File: rtl/dla_pkg.sv
package dla_pkg;

    localparam int DLA_NUM_LINES   = 6;
    localparam int DLA_ALLOC_LINES = 5;
    localparam int DLA_EP_W        = 4;
    localparam int DLA_REQ_W       = 7;

    typedef enum logic [1:0] {
        ST_NONE    = 2'd0,
        ST_GRANT   = 2'd1,
        ST_BUSY    = 2'd2,
        ST_REFUSED = 2'd3
    } dla_status_e;

    // Request-output number driven by each line index.
    function automatic logic [DLA_REQ_W-1:0] dla_line_reqnum(input int idx);
        case (idx)
            0:       return 7'd2;
            1:       return 7'd3;
            2:       return 7'd14;
            3:       return 7'd15;
            4:       return 7'd16;
            5:       return 7'd64;
            default: return 7'd0;
        endcase
    endfunction

endpackage

// File: rtl/dla_free_search.sv
// Lowest-index search over the allocatable lines.
module dla_free_search #(
    parameter  int ALLOC_LINES = 5,
    parameter  int LINE_W      = 3
) (
    input  logic [ALLOC_LINES-1:0] taken_i,
    output logic                   found_o,
    output logic [LINE_W-1:0]      idx_o
);

    logic [ALLOC_LINES-1:0] free_v;

    genvar g;
    generate
        for (g = 0; g < ALLOC_LINES; g++) begin : g_free
            assign free_v[g] = ~taken_i[g];
        end
    endgenerate

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = ALLOC_LINES - 1; i >= 0; i--) begin
            if (free_v[i]) begin
                found_o = 1'b1;
                idx_o   = LINE_W'(i);
            end
        end
    end

endmodule

// File: rtl/dla_mask_bit.sv
// One-hot interrupt mask position for an endpoint and direction.
module dla_mask_bit #(
    parameter  int EP_W   = 4,
    localparam int RX_OFS = (1 << EP_W) - 1,
    localparam int MASK_W = RX_OFS + (1 << EP_W)
) (
    input  logic [EP_W-1:0]   ep_i,
    input  logic              tx_i,
    output logic [MASK_W-1:0] bit_o
);

    logic [5:0] pos;

    always_comb begin
        pos   = tx_i ? 6'(ep_i) : 6'(ep_i) + 6'(RX_OFS);
        bit_o = MASK_W'(1) << pos;
    end

endmodule

// File: rtl/dla_reqnum_lut.sv
// Line index to request-output number.
module dla_reqnum_lut
    import dla_pkg::*;
#(
    parameter  int NUM_LINES = DLA_NUM_LINES,
    parameter  int LINE_W    = 3
) (
    input  logic [LINE_W-1:0]    idx_i,
    output logic [DLA_REQ_W-1:0] num_o
);

    logic [DLA_REQ_W-1:0] entry [NUM_LINES];

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_ent
            assign entry[g] = dla_line_reqnum(g);
        end
    endgenerate

    always_comb begin
        num_o = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (idx_i == LINE_W'(i)) num_o = entry[i];
        end
    end

endmodule

// File: rtl/dla_line_alloc.sv
module dla_line_alloc
    import dla_pkg::*;
#(
    parameter  int NUM_LINES   = DLA_NUM_LINES,
    parameter  int ALLOC_LINES = DLA_ALLOC_LINES,
    parameter  int EP_W        = DLA_EP_W,
    localparam int FIELD_W     = EP_W + 1,
    localparam int MAP_W       = NUM_LINES * FIELD_W,
    localparam int LINE_W      = $clog2(NUM_LINES),
    localparam int MASK_W      = 2 * (1 << EP_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shared_mode_i,
    input  logic                 alloc_req_i,
    input  logic [EP_W-1:0]      alloc_ep_i,
    input  logic                 alloc_tx_i,
    input  logic                 rel_req_i,
    input  logic [LINE_W-1:0]    rel_line_i,
    input  logic [EP_W-1:0]      rel_ep_i,
    output logic                 rsp_valid_o,
    output logic [1:0]           rsp_status_o,
    output logic [LINE_W-1:0]    rsp_line_o,
    output logic [DLA_REQ_W-1:0] rsp_reqnum_o,
    output logic [MAP_W-1:0]     map_o,
    output logic [MASK_W-1:0]    irq_mask_o,
    output logic [MASK_W-1:0]    irq_clr_o,
    output logic                 rel_err_o
);

    typedef struct packed {
        logic [MAP_W-1:0]     map;
        logic [MASK_W-1:0]    mask;
        logic [MASK_W-1:0]    clr;
        logic                 err;
        logic                 vld;
        dla_status_e          st;
        logic [LINE_W-1:0]    line;
        logic [DLA_REQ_W-1:0] reqnum;
    } state_t;

    state_t s_d, s_q;

    // Release stage signals
    logic [FIELD_W-1:0]     rel_fld;
    logic                   rel_hit;
    logic [MAP_W-1:0]       map_rel;
    logic [MASK_W-1:0]      rel_bit;

    // Allocate stage signals
    logic [ALLOC_LINES-1:0] taken_v;
    logic                   free_found;
    logic [LINE_W-1:0]      free_idx;
    logic [LINE_W-1:0]      grant_line;
    logic [DLA_REQ_W-1:0]   grant_num;
    logic [MASK_W-1:0]      alloc_bit;

    // Field selected by the release request
    always_comb begin
        rel_fld = '0;
        if (shared_mode_i) begin
            rel_fld = s_q.map[FIELD_W-1:0];
        end else begin
            for (int i = 0; i < ALLOC_LINES; i++) begin
                if (rel_line_i == LINE_W'(i)) rel_fld = s_q.map[i*FIELD_W +: FIELD_W];
            end
        end
    end

    always_comb begin
        rel_hit = rel_req_i && (rel_fld[EP_W-1:0] != '0) &&
                  (!shared_mode_i || rel_fld[EP_W-1:0] == rel_ep_i);
        map_rel = s_q.map;
        if (rel_hit) begin
            if (shared_mode_i) begin
                map_rel = '0;
            end else begin
                for (int i = 0; i < ALLOC_LINES; i++) begin
                    if (rel_line_i == LINE_W'(i)) map_rel[i*FIELD_W +: FIELD_W] = '0;
                end
            end
        end
    end

    dla_mask_bit #(.EP_W(EP_W)) u_rel_bit (
        .ep_i  (rel_fld[EP_W-1:0]),
        .tx_i  (rel_fld[EP_W]),
        .bit_o (rel_bit)
    );

    // Occupancy seen by the search, after the release is applied
    genvar g;
    generate
        for (g = 0; g < ALLOC_LINES; g++) begin : g_taken
            assign taken_v[g] = |map_rel[g*FIELD_W +: EP_W];
        end
    endgenerate

    dla_free_search #(.ALLOC_LINES(ALLOC_LINES), .LINE_W(LINE_W)) u_search (
        .taken_i (taken_v),
        .found_o (free_found),
        .idx_o   (free_idx)
    );

    dla_mask_bit #(.EP_W(EP_W)) u_alloc_bit (
        .ep_i  (alloc_ep_i),
        .tx_i  (alloc_tx_i),
        .bit_o (alloc_bit)
    );

    assign grant_line = shared_mode_i ? '0 : free_idx;

    dla_reqnum_lut #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_lut (
        .idx_i (grant_line),
        .num_o (grant_num)
    );

    // Next-state computation
    always_comb begin
        s_d        = s_q;
        s_d.map    = map_rel;
        s_d.clr    = '0;
        s_d.err    = rel_req_i && !rel_hit;
        s_d.vld    = alloc_req_i;
        s_d.st     = ST_NONE;
        s_d.line   = '0;
        s_d.reqnum = '0;

        if (rel_hit) begin
            s_d.mask = s_q.mask | rel_bit;
            s_d.clr  = rel_bit;
        end

        if (alloc_req_i) begin
            if (alloc_ep_i == '0) begin
                s_d.st = ST_REFUSED;
            end else if ((shared_mode_i && map_rel == '0) || (!shared_mode_i && free_found)) begin
                s_d.st     = ST_GRANT;
                s_d.line   = grant_line;
                s_d.reqnum = grant_num;
                s_d.mask   = s_d.mask & ~alloc_bit;
                if (shared_mode_i) begin
                    s_d.map = MAP_W'({alloc_tx_i, alloc_ep_i});
                end else begin
                    for (int i = 0; i < ALLOC_LINES; i++) begin
                        if (grant_line == LINE_W'(i)) s_d.map[i*FIELD_W +: FIELD_W] = {alloc_tx_i, alloc_ep_i};
                    end
                end
            end else begin
                s_d.st = ST_BUSY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.map    <= '0;
            s_q.mask   <= '1;
            s_q.clr    <= '0;
            s_q.err    <= 1'b0;
            s_q.vld    <= 1'b0;
            s_q.st     <= ST_NONE;
            s_q.line   <= '0;
            s_q.reqnum <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid_o  = s_q.vld;
    assign rsp_status_o = s_q.st;
    assign rsp_line_o   = s_q.line;
    assign rsp_reqnum_o = s_q.reqnum;
    assign map_o        = s_q.map;
    assign irq_mask_o   = s_q.mask;
    assign irq_clr_o    = s_q.clr;
    assign rel_err_o    = s_q.err;

endmodule

// File: rtl/dla_line_alloc_chk.sv
module dla_line_alloc_chk #(
    parameter int EP_W        = 4,
    parameter int LINE_W      = 3,
    parameter int MAP_W       = 30,
    parameter int MASK_W      = 31,
    parameter int ALLOC_LINES = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shared_mode_i,
    input logic              alloc_req_i,
    input logic [EP_W-1:0]   alloc_ep_i,
    input logic              rel_req_i,
    input logic              rsp_valid_o,
    input logic [1:0]        rsp_status_o,
    input logic [LINE_W-1:0] rsp_line_o,
    input logic [MAP_W-1:0]  map_o,
    input logic [MASK_W-1:0] irq_clr_o,
    input logic              rel_err_o
);

    assert_no_ep0_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_status_o == 2'd1) |-> ($past(alloc_ep_i) != '0));

    assert_line_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_status_o == 2'd1) |-> (32'(rsp_line_o) < ALLOC_LINES));

    assert_shared_line0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_status_o == 2'd1 && $past(shared_mode_i)) |-> (rsp_line_o == '0));

    assert_clr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_clr_o));

    assert_busy_keeps_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_status_o == 2'd2 && !$past(rel_req_i)) |-> (map_o == $past(map_o)));

    assert_err_keeps_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_err_o && !$past(alloc_req_i)) |-> (map_o == $past(map_o)));

    assert_err_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err_o |-> (irq_clr_o == '0));

endmodule

bind dla_line_alloc dla_line_alloc_chk #(
    .EP_W(EP_W), .LINE_W(LINE_W), .MAP_W(MAP_W), .MASK_W(MASK_W), .ALLOC_LINES(ALLOC_LINES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .shared_mode_i (shared_mode_i),
    .alloc_req_i   (alloc_req_i),
    .alloc_ep_i    (alloc_ep_i),
    .rel_req_i     (rel_req_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_status_o  (rsp_status_o),
    .rsp_line_o    (rsp_line_o),
    .map_o         (map_o),
    .irq_clr_o     (irq_clr_o),
    .rel_err_o     (rel_err_o)
);

// File: tb/dla_line_alloc_tb.sv
`timescale 1ns/1ps
module dla_line_alloc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shared_mode_i = 1'b0;
    logic        alloc_req_i = 1'b0;
    logic [3:0]  alloc_ep_i = '0;
    logic        alloc_tx_i = 1'b0;
    logic        rel_req_i = 1'b0;
    logic [2:0]  rel_line_i = '0;
    logic [3:0]  rel_ep_i = '0;
    logic        rsp_valid_o;
    logic [1:0]  rsp_status_o;
    logic [2:0]  rsp_line_o;
    logic [6:0]  rsp_reqnum_o;
    logic [29:0] map_o;
    logic [30:0] irq_mask_o;
    logic [30:0] irq_clr_o;
    logic        rel_err_o;

    int checks = 0;
    int errors = 0;

    logic [29:0] m_map;
    logic [30:0] m_mask;

    always #2 clk = ~clk;

    dla_line_alloc u_dut (
        .clk(clk), .rst_n(rst_n), .shared_mode_i(shared_mode_i),
        .alloc_req_i(alloc_req_i), .alloc_ep_i(alloc_ep_i), .alloc_tx_i(alloc_tx_i),
        .rel_req_i(rel_req_i), .rel_line_i(rel_line_i), .rel_ep_i(rel_ep_i),
        .rsp_valid_o(rsp_valid_o), .rsp_status_o(rsp_status_o), .rsp_line_o(rsp_line_o),
        .rsp_reqnum_o(rsp_reqnum_o), .map_o(map_o), .irq_mask_o(irq_mask_o),
        .irq_clr_o(irq_clr_o), .rel_err_o(rel_err_o)
    );

    function automatic logic [30:0] mbit(input logic [3:0] ep, input logic tx);
        return 31'(1) << (tx ? int'(ep) : int'(ep) + 15);
    endfunction

    function automatic logic [6:0] reqnum(input int line);
        case (line)
            0: return 7'd2;   1: return 7'd3;   2: return 7'd14;
            3: return 7'd15;  4: return 7'd16;  5: return 7'd64;
            default: return 7'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus and compare every output after the edge.
    task automatic cycle(input logic sh, input logic al, input logic [3:0] aep, input logic atx,
                         input logic rl, input logic [2:0] rline, input logic [3:0] rep);
        logic [4:0]  fld;
        logic        hit;
        logic [29:0] e_map;
        logic [30:0] e_mask, e_clr;
        logic        e_err;
        logic [1:0]  e_st;
        int          e_line;
        string       st_tag, rel_tag;

        shared_mode_i = sh; alloc_req_i = al; alloc_ep_i = aep; alloc_tx_i = atx;
        rel_req_i = rl; rel_line_i = rline; rel_ep_i = rep;

        e_map = m_map; e_mask = m_mask; e_clr = '0; e_err = 1'b0;
        fld = '0;
        if (sh) fld = m_map[4:0];
        else if (rline < 3'd5) fld = m_map[int'(rline)*5 +: 5];
        hit = rl && (fld[3:0] != 0) && (!sh || fld[3:0] == rep);
        rel_tag = sh ? "R9" : "R7";
        if (hit) begin
            if (sh) e_map = '0; else e_map[int'(rline)*5 +: 5] = '0;
            e_mask = e_mask | mbit(fld[3:0], fld[4]);
            e_clr  = mbit(fld[3:0], fld[4]);
        end else if (rl) e_err = 1'b1;

        e_st = 2'd0; e_line = 0; st_tag = "R3";
        if (al) begin
            if (aep == 0) begin
                e_st = 2'd3; st_tag = "R5";
            end else if (sh) begin
                st_tag = "R8";
                if (e_map == 0) begin
                    e_st = 2'd1; e_line = 0; e_map = 30'({atx, aep});
                end else e_st = 2'd2;
            end else begin
                e_line = -1;
                for (int i = 4; i >= 0; i--) if (e_map[i*5 +: 4] == 0) e_line = i;
                if (e_line >= 0) begin
                    e_st = 2'd1; e_map[e_line*5 +: 5] = {atx, aep};
                end else begin
                    e_st = 2'd2; e_line = 0; st_tag = "R4";
                end
            end
            if (e_st == 2'd1) e_mask = e_mask & ~mbit(aep, atx);
            if (e_st == 2'd1 && rl && hit) st_tag = "R12";
        end

        @(posedge clk); #1;
        chk(st_tag, "rsp_valid", 64'(rsp_valid_o), 64'(al));
        if (al) begin
            chk(st_tag, "status", 64'(rsp_status_o), 64'(e_st));
            chk(st_tag, "line", 64'(rsp_line_o), 64'(e_line));
            chk("R6", "reqnum", 64'(rsp_reqnum_o), 64'(e_st == 2'd1 ? reqnum(e_line) : 7'd0));
        end
        chk(rl ? "R12" : "R2", "map", 64'(map_o), 64'(e_map));
        chk("R10", "mask", 64'(irq_mask_o), 64'(e_mask));
        chk("R11", "clear", 64'(irq_clr_o), 64'(e_clr));
        chk(rel_tag, "rel_err", 64'(rel_err_o), 64'(e_err));
        m_map = e_map; m_mask = e_mask;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        m_map = '0; m_mask = 31'h7FFF_FFFF;
        // R1 reset state
        chk("R1", "map", 64'(map_o), 64'd0);
        chk("R1", "mask", 64'(irq_mask_o), 64'h7FFF_FFFF);
        chk("R1", "clear", 64'(irq_clr_o), 64'd0);
        chk("R1", "rsp_valid", 64'(rsp_valid_o), 64'd0);
        chk("R1", "rel_err", 64'(rel_err_o), 64'd0);

        // Fill all five lines, then overflow and endpoint 0
        cycle(0, 1, 4'd1, 1, 0, 0, 0);
        cycle(0, 1, 4'd2, 0, 0, 0, 0);
        cycle(0, 1, 4'd3, 1, 0, 0, 0);
        cycle(0, 1, 4'd15, 0, 0, 0, 0);
        cycle(0, 1, 4'd5, 1, 0, 0, 0);
        cycle(0, 1, 4'd6, 1, 0, 0, 0);           // R4 busy
        cycle(0, 1, 4'd0, 1, 0, 0, 0);           // R5 refused
        cycle(0, 0, 4'd0, 0, 1, 3'd2, 0);        // R7 release line 2
        cycle(0, 1, 4'd7, 0, 0, 0, 0);           // R3 reuse line 2
        cycle(0, 0, 4'd0, 0, 1, 3'd5, 0);        // R7 line 5 rejected
        cycle(0, 1, 4'd9, 0, 1, 3'd0, 0);        // R12 same-cycle
        for (int k = 0; k < 5; k++) cycle(0, 0, 0, 0, 1, 3'(k), 0);
        cycle(0, 0, 4'd0, 0, 1, 3'd1, 0);        // R7 empty line rejected

        // Shared mode
        cycle(1, 1, 4'd4, 1, 0, 0, 0);           // R8 grant
        cycle(1, 1, 4'd5, 0, 0, 0, 0);           // R8 busy
        cycle(1, 0, 4'd0, 0, 1, 0, 4'd6);        // R9 mismatch
        cycle(1, 1, 4'd8, 0, 1, 0, 4'd4);        // R12 release then grant
        cycle(1, 0, 4'd0, 0, 1, 0, 4'd8);        // R9 honoured

        // Constrained random
        for (int n = 0; n < 4000; n++) begin
            logic sh;
            sh = (n >= 2000);
            if (n == 2000) for (int k = 0; k < 5; k++) cycle(0, 0, 0, 0, 1, 3'(k), 0);
            cycle(sh, ($urandom % 3) != 0, 4'($urandom % 16), 1'($urandom % 2),
                  ($urandom % 3) == 0, 3'($urandom % 7),
                  (($urandom % 2) == 0) ? m_map[3:0] : 4'($urandom % 16));
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule